// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable single-port synchronous SRAM core. Reads and writes can follow each other on consecutive clock edges with no idle cycle between them. Every edge samples the command, address and lane strobes. Write data is taken a fixed number of edges after its command. A read drives its data on the output bus in the same relative cycle, so the shared data phase never has to turn around.

The `flow_sel_n` strap chooses between two modes. In flow-through mode the latency is one edge. In pipelined mode it is two edges, and read data comes from an output register. The word is split into 9-bit lanes, each with its own active-low write strobe. Three chip enables must all be active for a command to be taken. Output enable and sleep act on the output drive without waiting for a clock. A write whose data has not yet reached the array is forwarded to a read of the same address, so reads always observe command order.

Top module: `zt_sram`

## Requirements
- R1: A command is taken at a rising edge only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination is a deselect: it writes nothing and leaves `dq_oe` low in its data phase.
- R2: With `flow_sel_n`=0 (flow-through), a read taken at edge n drives `dq_out` with `dq_oe`=1 between edge n and edge n+1.
- R3: With `flow_sel_n`=1 (pipelined), a read taken at edge n drives `dq_out` with `dq_oe`=1 between edge n+1 and edge n+2.
- R4: The write data of a write taken at edge n is sampled from `wdata` at edge n+1 (flow-through) or edge n+2 (pipelined). `wdata` at any other edge has no effect.
- R5: `lane_we_n[i]`=0 writes bits [9i+8:9i], and `lane_we_n[i]`=1 leaves those bits unchanged. All strobes high writes nothing.
- R6: A read returns the word that all earlier writes produced in command order. This includes a write taken at the edge just before the read, whose data is still pending.
- R7: `dq_oe` is low in a write's data phase and in an idle phase. Any mix of reads and writes runs on consecutive edges with no gap.
- R8: `oe_n`=1 forces `dq_oe` low at once, without waiting for a clock edge.
- R9: `sleep`=1 forces `dq_oe` low at once, and a command presented at an edge while `sleep`=1 is ignored.
- R10: After reset, `dq_oe` is low and no command is pending. `flow_sel_n` may change only while reset is held. Array contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flow_sel_n | input | 1 | Mode strap: 0 flow-through, 1 pipelined |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 write, 1 read |
| addr | input | AW | Word address |
| lane_we_n | input | NL | Per-lane write strobes, active low |
| wdata | input | NL*LW | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| dq_out | output | NL*LW | Read data, zero when not driven |
| dq_oe | output | 1 | Output drive enable (0 means high impedance) |

## Verification
A wrong command stage shows at the ports in the first data phase after it goes wrong. A read would drive one edge early or late, or a write phase would drive the bus, so `dq_oe` would differ from the model in that very cycle. A wrong array word or a missed forward stays hidden until that address is read. The random mix uses only eight addresses, which keeps that delay to a few cycles. Lost lane strobes show up as partial-word mismatches on the first read-back.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] lane_we_n,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output logic [NL-1:0] s1_mask,
  output op_e           s2_op,
  output logic [AW-1:0] s2_addr,
  output logic [NL-1:0] s2_mask
);
  op_e s1_op_d;
  logic s1_en, s2_en;

  always_comb begin
    s1_en = take;
    s2_en = (s1_op != OP_IDLE);
    if (!take)     s1_op_d = OP_IDLE;
    else if (wr_n) s1_op_d = OP_READ;
    else           s1_op_d = OP_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op <= OP_IDLE;
      s2_op <= OP_IDLE;
    end else begin
      s1_op <= s1_op_d;
      s2_op <= s1_op;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_addr <= addr;
      s1_mask <= ~lane_we_n;
    end
    if (s2_en) begin
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
    end
  end
endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NL-1:0]    wr_mask,
  input  logic [NL*LW-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NL*LW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];
    logic          lane_en;

    always_comb lane_en = wr_en && wr_mask[g];

    always_ff @(posedge clk) begin
      if (lane_en) lane_mem[wr_addr] <= wr_data[g*LW +: LW];
    end

    always_comb rd_data[g*LW +: LW] = lane_mem[rd_addr];
  end
endmodule

// File: rtl/zt_read_path.sv
module zt_read_path
  import zt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             pipe_mode,
  input  op_e              s1_op,
  input  logic [AW-1:0]    s1_addr,
  input  op_e              s2_op,
  input  logic [AW-1:0]    s2_addr,
  input  logic [NL-1:0]    s2_mask,
  input  logic [NL*LW-1:0] wdata,
  input  logic [NL*LW-1:0] arr_data,
  output logic [NL*LW-1:0] rd_word
);
  localparam int DW = NL * LW;

  logic          fwd_hit;
  logic          dout_en;
  logic [DW-1:0] merged;
  logic [DW-1:0] dout_q;

  always_comb begin
    fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);
    dout_en = pipe_mode && (s1_op == OP_READ);
  end

  for (genvar g = 0; g < NL; g++) begin : g_merge
    always_comb merged[g*LW +: LW] = (fwd_hit && s2_mask[g]) ? wdata[g*LW +: LW]
                                                             : arr_data[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (dout_en) dout_q <= merged;
  end

  always_comb rd_word = pipe_mode ? dout_q : arr_data;
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_sel_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [NL-1:0]    lane_we_n,
  input  logic [NL*LW-1:0] wdata,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [NL*LW-1:0] dq_out,
  output logic             dq_oe
);
  localparam int DW = NL * LW;

  logic [1:0]    rst_q;
  logic          rst_int_n;
  logic          pipe_mode;
  logic          take;
  op_e           s1_op, s2_op;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NL-1:0] s1_mask, s2_mask;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [NL-1:0] wr_mask;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] rd_word;
  logic          phase_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end

  always_comb begin
    rst_int_n = rst_q[1];
    pipe_mode = flow_sel_n;
    take      = !cs1_n && cs2 && !cs3_n && !sleep;
    wr_en     = pipe_mode ? (s2_op == OP_WRITE) : (s1_op == OP_WRITE);
    wr_addr   = pipe_mode ? s2_addr : s1_addr;
    wr_mask   = pipe_mode ? s2_mask : s1_mask;
    phase_rd  = pipe_mode ? (s2_op == OP_READ) : (s1_op == OP_READ);
    dq_oe     = phase_rd && !oe_n && !sleep;
    dq_out    = dq_oe ? rd_word : '0;
  end

  zt_cmd_pipe #(.AW(AW), .NL(NL)) u_cmd (
    .clk(clk), .rst_n(rst_int_n), .take(take), .wr_n(wr_n), .addr(addr),
    .lane_we_n(lane_we_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_mask(s1_mask),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_mask(s2_mask)
  );

  zt_lane_array #(.AW(AW), .NL(NL), .LW(LW)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .wr_data(wdata), .rd_addr(s1_addr), .rd_data(arr_data)
  );

  zt_read_path #(.AW(AW), .NL(NL), .LW(LW)) u_read (
    .clk(clk), .pipe_mode(pipe_mode), .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_mask(s2_mask), .wdata(wdata),
    .arr_data(arr_data), .rd_word(rd_word)
  );

  // R1: a deselected edge leaves its data phase undriven
  p_desel_quiet_ft_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!take && !flow_sel_n) |=> !dq_oe);
  p_desel_quiet_pl_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!take && flow_sel_n) |=> ##1 !dq_oe);

  // R7: write data phases never drive the bus
  p_write_phase_quiet_ft_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take && !wr_n && !flow_sel_n) |=> !dq_oe);
  p_write_phase_quiet_pl_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take && !wr_n && flow_sel_n) |=> ##1 !dq_oe);

  // R8: output enable override
  p_oe_override_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    oe_n |-> !dq_oe);

  // R9: sleep silences the bus
  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    sleep |-> !dq_oe);

  // R10: mode strap only moves under reset
  p_mode_static_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $stable(flow_sel_n));
endmodule

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, flow_sel_n, cs1_n, cs2, cs3_n, wr_n, oe_n, sleep;
  logic [AW-1:0] addr;
  logic [NL-1:0] lane_we_n;
  logic [DW-1:0] wdata, dq_out;
  logic          dq_oe;

  zt_sram #(.AW(AW), .NL(NL), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flow_sel_n(flow_sel_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .wr_n(wr_n), .addr(addr), .lane_we_n(lane_we_n), .wdata(wdata),
    .oe_n(oe_n), .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  logic [DW-1:0] ref_mem [DEPTH];
  int            slot_kind [4];   // 0 none, 1 read, 2 write
  logic [DW-1:0] slot_data [4];
  int n, lat, checks, errors;
  bit done;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, n);
    end
  endtask

  // kind: 0 read, 1 write; csv: 0 selected, 1..3 one enable inactive
  task automatic step(input int kind, input int a, input logic [NL-1:0] mn,
                      input int csv, input logic oev, input logic slp, input string tag);
    int ph, cur;
    logic exp_oe;
    string otag;
    logic [DW-1:0] d;
    @(negedge clk);
    ph = (n - lat) & 3;
    cur = n & 3;
    oe_n = oev;
    sleep = slp;
    wdata = (slot_kind[ph] == 2) ? slot_data[ph] : DW'({$urandom, $urandom});
    cs1_n = (csv == 1);
    cs2   = (csv != 2);
    cs3_n = (csv == 3);
    wr_n  = (kind != 1);
    addr  = AW'(a);
    lane_we_n = mn;
    #1;
    exp_oe = (slot_kind[ph] == 1) && !oev && !slp;
    if (slp)                    otag = "R9";
    else if (oev)               otag = "R8";
    else if (slot_kind[ph] == 1) otag = (lat == 1) ? "R2" : "R3";
    else if (slot_kind[ph] == 2) otag = "R7";
    else                        otag = "R1";
    check(dq_oe == exp_oe, otag, DW'(dq_oe), DW'(exp_oe));
    if (exp_oe && dq_oe) check(dq_out == slot_data[ph], tag, dq_out, slot_data[ph]);
    if (csv != 0 || slp) begin
      slot_kind[cur] = 0;
    end else if (kind == 1) begin
      d = DW'({$urandom, $urandom});
      for (int i = 0; i < NL; i++)
        if (!mn[i]) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
      slot_kind[cur] = 2;
      slot_data[cur] = d;
    end else begin
      slot_kind[cur] = 1;
      slot_data[cur] = ref_mem[a];
    end
    n++;
  endtask

  task automatic drain();
    repeat (4) step(0, 0, '1, 1, 1'b0, 1'b0, "R1");
  endtask

  task automatic do_reset(input bit pipe);
    @(negedge clk);
    rst_n = 1'b0;
    flow_sel_n = pipe;
    cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; oe_n = 1'b0; sleep = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) slot_kind[i] = 0;
    n = 0;
    lat = pipe ? 2 : 1;
    #1;
    check(dq_oe == 1'b0, "R10", DW'(dq_oe), '0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, '1, 2, 1'b0, 1'b0, "R10");
  endtask

  task automatic directed();
    step(1, 9, '0, 0, 1'b0, 1'b0, "R4");
    drain();
    step(0, 9, '1, 0, 1'b0, 1'b0, "R4");
    step(1, 9, 4'b1010, 0, 1'b0, 1'b0, "R5");
    drain();
    step(0, 9, '1, 0, 1'b0, 1'b0, "R5");
    step(1, 9, 4'b1111, 0, 1'b0, 1'b0, "R5");
    drain();
    step(0, 9, '1, 0, 1'b0, 1'b0, "R5");
    step(1, 10, 4'b0110, 0, 1'b0, 1'b0, "R6");
    step(0, 10, '1, 0, 1'b0, 1'b0, "R6");
    step(1, 10, 4'b0000, 0, 1'b0, 1'b0, "R6");
    step(0, 10, '1, 0, 1'b0, 1'b0, "R6");
    step(0, 10, '1, 0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 8; i++) step(i % 2 == 0 ? 1 : 0, 11 + (i / 2) % 2,
                                     4'(i * 5), 0, 1'b0, 1'b0, "R7");
    for (int c = 1; c < 4; c++) begin
      step(1, 13, '0, c, 1'b0, 1'b0, "R1");
      step(0, 13, '1, 0, 1'b0, 1'b0, "R1");
    end
    step(1, 14, '0, 0, 1'b0, 1'b1, "R9");
    step(0, 14, '1, 0, 1'b0, 1'b0, "R9");
    step(0, 14, '1, 0, 1'b0, 1'b1, "R9");
    step(0, 15, '1, 0, 1'b1, 1'b0, "R8");
    step(0, 15, '1, 0, 1'b1, 1'b0, "R8");
    step(0, 15, '1, 0, 1'b0, 1'b0, "R8");
    drain();
  endtask

  task automatic random_mix(input int count);
    for (int i = 0; i < count; i++) begin
      int csv;
      csv = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 3)) : 0;
      step(int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), NL'($urandom),
           csv, ($urandom_range(0, 9) == 0), ($urandom_range(0, 19) == 0), "R6");
    end
    drain();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0; n = 0; lat = 1;
    rst_n = 1'b0; flow_sel_n = 1'b0; wr_n = 1'b1; addr = '0; lane_we_n = '1;
    wdata = '0; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; oe_n = 1'b0; sleep = 1'b0;
    for (int i = 0; i < 4; i++) begin slot_kind[i] = 0; slot_data[i] = '0; end
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) step(1, i, '0, 0, 1'b0, 1'b0, "R4");
    drain();
    directed();
    random_mix(300);
    do_reset(1'b1);
    step(0, 9, '1, 0, 1'b0, 1'b0, "R10");
    directed();
    random_mix(300);
    done = 1;
    summary();
    $finish;
  end
endmodule